// File: doc/BRIEF.md
# Single-Bit Hamming Sector ECC

This block builds a 24-bit Hamming parity code over one flash sector (512 bytes by default) while the sector's bytes stream past during a page program or a page read. Each data bit at bit address A, made of a 9-bit byte offset and a 3-bit bit index, is folded into two 12-bit halves. The "odd" half collects A and the "even" half collects the complement of A. Every chip select has its own parity context. A context is started by its restart bit, fed only by bytes tagged with that chip select, and read out, and so cleared, through a readout port. That port returns both the raw parity register and the packed, inverted 24-bit code that firmware stores next to the sector.

After a read, software hands the code stored in the spare area and the freshly computed code to the compare port. One clock later the block reports a 2-bit classification. A single flipped data bit is reported together with its byte offset and bit index. A single flipped bit inside the stored code needs no data change. Every other mismatch is reported as uncorrectable. Applying the fix to the data buffer is left to the caller.

Top module: `ecc1_hamming`

## Requirements
- R1: The raw readout holds the even half in bits 11:0 and the odd half in bits 27:16, with all other bits zero. Odd bit k is the XOR of every data bit whose 12-bit bit address {byte offset, bit index} has bit k set. Even bit k covers the data bits whose address has bit k clear. The code readout is the bitwise inverse of {odd, even}, so the odd half sits in 23:12.
- R2: A sector of all 0xFF bytes yields a code of 0xFFFFFF, and comparing it with a stored 0xFFFFFF reports clean.
- R3: A read request for a chip select returns that context on the next clock with rd_valid high for one cycle. The same request clears the parity and leaves the context stopped until its next restart.
- R4: Restart bit c clears context c and starts it. A context accumulates only bytes whose in_cs equals its index, and only while it is started.
- R5: in_sof marks byte offset 0. Later bytes take consecutive offsets, and bytes at offsets of SECTOR_BYTES or more change no context.
- R6: A compare request produces res_valid for exactly one cycle on the next clock. res_status encodes 0 = clean, 1 = data bit corrected, 2 = error in the stored code, 3 = uncorrectable.
- R7: When the stored and computed codes are equal, the status is 0.
- R8: Let diff be stored XOR computed. When diff[23:12] XOR diff[11:0] equals 0xFFF, the status is 1, res_byte equals diff[23:15] and res_bit equals diff[14:12].
- R9: A case that meets the R8 test but whose byte offset is not below SECTOR_BYTES is reported with status 3.
- R10: A diff with exactly one bit set gives status 2. Whenever the status is not 1, res_byte and res_bit read zero.
- R11: Any other nonzero diff gives status 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | A data byte is present this cycle |
| in_sof | input | 1 | The present byte is offset 0 of a sector |
| in_cs | input | CS_W | Chip select the byte belongs to |
| in_byte | input | 8 | Data byte |
| restart | input | NUM_CS | Per-chip-select clear-and-start bits |
| rd_en | input | 1 | Read (and clear) one context |
| rd_cs | input | CS_W | Context to read |
| rd_valid | output | 1 | Readout valid |
| rd_raw | output | 32 | Raw parity register (even 11:0, odd 27:16) |
| rd_code | output | 24 | Packed, inverted code |
| cmp_req | input | 1 | Compare request |
| cmp_stored | input | 24 | Code kept with the sector |
| cmp_calc | input | 24 | Freshly computed code |
| res_valid | output | 1 | Classification valid |
| res_status | output | 2 | Classification code |
| res_byte | output | 9 | Byte offset of the bad data bit |
| res_bit | output | 3 | Bit index of the bad data bit |

## Verification
The bench goes after both ends of the offset range: offset 0 bit 0, where the whole odd half is zero, and offset 511 bit 7, where the whole even half is zero. A classifier that tested the halves the wrong way round, or sliced the offset one bit off, would point at the wrong byte there. A second instance with a 256-byte sector takes a diff that passes the halves test but names offset 300. A design without the range check would call it correctable and point outside the buffer. Single-bit code errors at both ends of the code, an all-ones diff and a diff that fails the halves test check the split between statuses 2 and 3. Streamed sectors check that an erased sector reads clean, that a read clears the context, that a stopped or foreign context keeps still, and that a byte past the sector end is dropped. A design that skipped the inversion, leaked bytes across chip selects or kept counting past the end would read back the wrong code.

// File: rtl/ecc1_pkg.sv
package ecc1_pkg;

  localparam int OFF_W  = 9;
  localparam int HALF_W = OFF_W + 3;
  localparam int CODE_W = 2 * HALF_W;
  localparam int RAW_W  = 32;

  typedef enum logic [1:0] {
    ST_CLEAN    = 2'd0,
    ST_DATA_FIX = 2'd1,
    ST_CODE_BIT = 2'd2,
    ST_BAD      = 2'd3
  } ecc_status_e;

  typedef struct packed {
    ecc_status_e        st;
    logic [OFF_W-1:0]   off;
    logic [2:0]         bidx;
  } ecc_result_t;

  // par = {odd, even}; fold one byte at a given offset into it
  function automatic logic [CODE_W-1:0] par_step(input logic [CODE_W-1:0] par,
                                                 input logic [7:0] b,
                                                 input logic [OFF_W-1:0] off);
    logic [HALF_W-1:0] odd, even, a;
    odd  = par[CODE_W-1:HALF_W];
    even = par[HALF_W-1:0];
    for (int i = 0; i < 8; i++) begin
      a = {off, 3'(i)};
      if (b[i]) begin
        odd  = odd ^ a;
        even = even ^ ~a;
      end
    end
    return {odd, even};
  endfunction

  function automatic logic [RAW_W-1:0] pack_raw(input logic [CODE_W-1:0] par);
    return {4'b0, par[CODE_W-1:HALF_W], 4'b0, par[HALF_W-1:0]};
  endfunction

  function automatic ecc_result_t classify(input logic [CODE_W-1:0] stored,
                                           input logic [CODE_W-1:0] calc,
                                           input int unsigned lim);
    ecc_result_t       r;
    logic [CODE_W-1:0] d;
    logic [HALF_W-1:0] x;
    d = stored ^ calc;
    x = d[CODE_W-1:HALF_W] ^ d[HALF_W-1:0];
    r = '{st: ST_CLEAN, off: '0, bidx: '0};
    if (d == '0) begin
      r.st = ST_CLEAN;
    end else if (x == '1) begin
      if (32'(d[CODE_W-1:HALF_W+3]) < lim) begin
        r.st   = ST_DATA_FIX;
        r.off  = d[CODE_W-1:HALF_W+3];
        r.bidx = d[HALF_W+2:HALF_W];
      end else begin
        r.st = ST_BAD;
      end
    end else if ((d & (d - 1'b1)) == '0) begin
      r.st = ST_CODE_BIT;
    end else begin
      r.st = ST_BAD;
    end
    return r;
  endfunction

endpackage

// File: rtl/ecc1_offset_ctr.sv
module ecc1_offset_ctr
  import ecc1_pkg::*;
#(
  parameter int SECTOR_BYTES = 512
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic             in_sof,
  output logic [OFF_W-1:0] off,
  output logic             in_range
);
  localparam int CNT_W = OFF_W + 1;

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cur;

  assign cur      = in_sof ? '0 : cnt_q;
  assign in_range = 32'(cur) < SECTOR_BYTES;
  assign off      = cur[OFF_W-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else if (in_valid && in_range) cnt_q <= cur + 1'b1;
  end

  // R5: the offset counter never runs past the sector end
  a_r5_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
    32'(cnt_q) <= SECTOR_BYTES);

  // R5: a start-of-sector byte is taken at offset 0, so the next one is 1
  a_r5_sof_restarts: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_sof |=> cnt_q == CNT_W'(1));

endmodule

// File: rtl/ecc1_cs_acc.sv
module ecc1_cs_acc
  import ecc1_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              restart,
  input  logic              rd_clr,
  input  logic              take,
  input  logic [7:0]        in_byte,
  input  logic [OFF_W-1:0]  off,
  output logic [CODE_W-1:0] par,
  output logic              armed
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      par   <= '0;
      armed <= 1'b0;
    end else if (restart) begin
      par   <= '0;
      armed <= 1'b1;
    end else if (rd_clr) begin
      par   <= '0;
      armed <= 1'b0;
    end else if (take && armed) begin
      par <= par_step(par, in_byte, off);
    end
  end

  // R3: a stopped context holds no parity
  a_r3_stopped_is_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !armed |-> par == '0);

  // R4: without a tagged byte or control, the context keeps still
  a_r4_hold_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !take && !restart && !rd_clr |=> $stable(par));

endmodule

// File: rtl/ecc1_classifier.sv
module ecc1_classifier
  import ecc1_pkg::*;
#(
  parameter int SECTOR_BYTES = 512
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmp_req,
  input  logic [CODE_W-1:0] cmp_stored,
  input  logic [CODE_W-1:0] cmp_calc,
  output logic              res_valid,
  output ecc_result_t       res_q
);
  ecc_result_t res_d;
  logic        codes_equal;

  assign res_d       = classify(cmp_stored, cmp_calc, SECTOR_BYTES);
  assign codes_equal = (cmp_stored == cmp_calc);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_valid <= 1'b0;
      res_q     <= '{st: ST_CLEAN, off: '0, bidx: '0};
    end else begin
      res_valid <= cmp_req;
      if (cmp_req) res_q <= res_d;
    end
  end

  // R6: one result per request, on the next clock
  a_r6_result_follows: assert property (@(posedge clk) disable iff (!rst_n)
    cmp_req |=> res_valid);
  a_r6_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
    !cmp_req |=> !res_valid);

  // R7: equal codes are always clean
  a_r7_equal_is_clean: assert property (@(posedge clk) disable iff (!rst_n)
    cmp_req && codes_equal |=> res_q.st == ST_CLEAN);

  // R9: a reported data fix always lies inside the sector
  a_r9_fix_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && res_q.st == ST_DATA_FIX |-> 32'(res_q.off) < SECTOR_BYTES);

  // R10: no position is given unless a data bit is fixed
  a_r10_no_pos: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && res_q.st != ST_DATA_FIX |-> res_q.off == '0 && res_q.bidx == '0);

endmodule

// File: rtl/ecc1_hamming.sv
module ecc1_hamming
  import ecc1_pkg::*;
#(
  parameter int SECTOR_BYTES = 512,
  parameter int NUM_CS       = 4,
  localparam int CS_W        = (NUM_CS > 1) ? $clog2(NUM_CS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic              in_sof,
  input  logic [CS_W-1:0]   in_cs,
  input  logic [7:0]        in_byte,
  input  logic [NUM_CS-1:0] restart,
  input  logic              rd_en,
  input  logic [CS_W-1:0]   rd_cs,
  output logic              rd_valid,
  output logic [31:0]       rd_raw,
  output logic [23:0]       rd_code,
  input  logic              cmp_req,
  input  logic [23:0]       cmp_stored,
  input  logic [23:0]       cmp_calc,
  output logic              res_valid,
  output logic [1:0]        res_status,
  output logic [8:0]        res_byte,
  output logic [2:0]        res_bit
);
  logic [OFF_W-1:0]  off;
  logic              in_range;
  logic [CODE_W-1:0] par_arr [NUM_CS];
  logic [NUM_CS-1:0] armed_vec;
  logic [CODE_W-1:0] rd_sel;
  logic [CODE_W-1:0] rd_q;
  ecc_result_t       res_q;

  ecc1_offset_ctr #(.SECTOR_BYTES(SECTOR_BYTES)) u_off (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sof(in_sof),
    .off(off), .in_range(in_range));

  for (genvar g = 0; g < NUM_CS; g++) begin : g_cs
    logic take_g, clr_g;
    assign take_g = in_valid && in_range && (in_cs == CS_W'(g));
    assign clr_g  = rd_en && (rd_cs == CS_W'(g));
    ecc1_cs_acc u_acc (
      .clk(clk), .rst_n(rst_n), .restart(restart[g]), .rd_clr(clr_g),
      .take(take_g), .in_byte(in_byte), .off(off),
      .par(par_arr[g]), .armed(armed_vec[g]));
  end

  always_comb begin
    rd_sel = '0;
    for (int c = 0; c < NUM_CS; c++)
      if (rd_cs == CS_W'(c)) rd_sel = par_arr[c];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_valid <= 1'b0;
      rd_q     <= '0;
    end else begin
      rd_valid <= rd_en;
      if (rd_en) rd_q <= rd_sel;
    end
  end

  assign rd_raw  = pack_raw(rd_q);
  assign rd_code = ~rd_q;

  ecc1_classifier #(.SECTOR_BYTES(SECTOR_BYTES)) u_cls (
    .clk(clk), .rst_n(rst_n), .cmp_req(cmp_req), .cmp_stored(cmp_stored),
    .cmp_calc(cmp_calc), .res_valid(res_valid), .res_q(res_q));

  assign res_status = res_q.st;
  assign res_byte   = res_q.off;
  assign res_bit    = res_q.bidx;

  // R3: a readout follows every read request and nothing else
  a_r3_read_latency: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |=> rd_valid);
  a_r3_read_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> !rd_valid);

  // R3: a read without a restart leaves that context stopped
  a_r3_read_stops: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en && !restart[rd_cs] |=> !armed_vec[$past(rd_cs)]);

  // R1: the spare bits of the raw readout are always zero
  a_r1_raw_spare_zero: assert property (@(posedge clk) disable iff (!rst_n)
    rd_raw[31:28] == 4'b0 && rd_raw[15:12] == 4'b0);

endmodule

// File: tb/ecc1_hamming_tb_top.sv
module ecc1_hamming_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0, in_sof = 1'b0;
  logic [1:0]  in_cs = '0;
  logic [7:0]  in_byte = '0;
  logic [3:0]  restart = '0;
  logic        rd_en = 1'b0;
  logic [1:0]  rd_cs = '0;
  logic        cmp_req = 1'b0;
  logic [23:0] cmp_stored = '0, cmp_calc = '0;

  logic        rd_valid, res_valid;
  logic [31:0] rd_raw;
  logic [23:0] rd_code;
  logic [1:0]  res_status;
  logic [8:0]  res_byte;
  logic [2:0]  res_bit;

  logic        rd_valid_s, res_valid_s;
  logic [31:0] rd_raw_s;
  logic [23:0] rd_code_s;
  logic [1:0]  res_status_s;
  logic [8:0]  res_byte_s;
  logic [2:0]  res_bit_s;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  ecc1_hamming dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sof(in_sof),
    .in_cs(in_cs), .in_byte(in_byte), .restart(restart), .rd_en(rd_en),
    .rd_cs(rd_cs), .rd_valid(rd_valid), .rd_raw(rd_raw), .rd_code(rd_code),
    .cmp_req(cmp_req), .cmp_stored(cmp_stored), .cmp_calc(cmp_calc),
    .res_valid(res_valid), .res_status(res_status), .res_byte(res_byte),
    .res_bit(res_bit));

  ecc1_hamming #(.SECTOR_BYTES(256)) dut_small_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sof(in_sof),
    .in_cs(in_cs), .in_byte(in_byte), .restart(restart), .rd_en(rd_en),
    .rd_cs(rd_cs), .rd_valid(rd_valid_s), .rd_raw(rd_raw_s), .rd_code(rd_code_s),
    .cmp_req(cmp_req), .cmp_stored(cmp_stored), .cmp_calc(cmp_calc),
    .res_valid(res_valid_s), .res_status(res_status_s), .res_byte(res_byte_s),
    .res_bit(res_bit_s));

  // {stored, calc, status, byte, bit, status for 256-byte sector}
  localparam logic [63:0] VEC [11] = '{
    {24'hFFFFFF, 24'hFFFFFF, 2'd0, 9'd0,   3'd0, 2'd0},
    {24'hFFFFFF, 24'hFD402B, 2'd1, 9'd5,   3'd3, 2'd1},
    {24'hFFFFFF, 24'h000FFF, 2'd1, 9'd511, 3'd7, 2'd3},
    {24'h123456, 24'h123BA9, 2'd1, 9'd0,   3'd0, 2'd1},
    {24'hABCDEF, 24'hABCDEE, 2'd2, 9'd0,   3'd0, 2'd2},
    {24'h000000, 24'h800000, 2'd2, 9'd0,   3'd0, 2'd2},
    {24'h000000, 24'h000003, 2'd3, 9'd0,   3'd0, 2'd3},
    {24'h000000, 24'h123456, 2'd3, 9'd0,   3'd0, 2'd3},
    {24'h000000, 24'hFFFFFF, 2'd3, 9'd0,   3'd0, 2'd3},
    {24'h000000, 24'h96269D, 2'd1, 9'd300, 3'd2, 2'd3},
    {24'h000000, 24'h7F9806, 2'd1, 9'd255, 3'd1, 2'd1}
  };

  logic [7:0] sect [512];

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // independent model: one parity bit at a time over every bit address
  function automatic logic [31:0] model_raw(input int n);
    logic [11:0] odd, even;
    odd = '0; even = '0;
    for (int k = 0; k < 12; k++) begin
      for (int a = 0; a < n * 8; a++) begin
        if (sect[a / 8][a % 8]) begin
          if (a[k]) odd[k] = ~odd[k];
          else      even[k] = ~even[k];
        end
      end
    end
    return {4'h0, odd, 4'h0, even};
  endfunction

  function automatic logic [23:0] code_of(input logic [31:0] raw);
    return ~{raw[27:16], raw[11:0]};
  endfunction

  task automatic pulse_restart(input logic [3:0] m);
    @(negedge clk); restart = m;
    @(negedge clk); restart = '0;
  endtask

  task automatic stream(input logic [1:0] cs, input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid = 1'b1; in_cs = cs; in_byte = sect[i]; in_sof = (i == 0);
    end
    @(negedge clk);
    in_valid = 1'b0; in_sof = 1'b0;
  endtask

  task automatic read_ctx(input logic [1:0] cs, output logic [31:0] raw,
                          output logic [23:0] code);
    @(negedge clk); rd_en = 1'b1; rd_cs = cs;
    @(negedge clk); rd_en = 1'b0;
    chk("R3", "rd_valid", 32'(rd_valid), 32'd1);
    raw = rd_raw; code = rd_code;
  endtask

  task automatic compare(input logic [23:0] s, input logic [23:0] c);
    @(negedge clk); cmp_req = 1'b1; cmp_stored = s; cmp_calc = c;
    @(negedge clk); cmp_req = 1'b0;
    chk("R6", "res_valid", 32'(res_valid), 32'd1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] raw, exp_raw;
    logic [23:0] code, code_a;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R6", "reset res_valid", 32'(res_valid), 32'd0);
    chk("R3", "reset rd_valid", 32'(rd_valid), 32'd0);
    chk("R6", "reset res_status", 32'(res_status), 32'd0);

    // vector table: classification of code pairs
    foreach (VEC[v]) begin
      logic [63:0] e;
      e = VEC[v];
      compare(e[63:40], e[39:16]);
      chk("R7 R8 R10 R11", $sformatf("vec %0d status", v), 32'(res_status), 32'(e[15:14]));
      chk("R8 R10", $sformatf("vec %0d byte", v), 32'(res_byte), 32'(e[13:5]));
      chk("R8 R10", $sformatf("vec %0d bit", v), 32'(res_bit), 32'(e[4:2]));
      chk("R9", $sformatf("vec %0d small status", v), 32'(res_status_s), 32'(e[1:0]));
      if (e[1:0] != 2'd1) begin
        chk("R9 R10", $sformatf("vec %0d small byte", v), 32'(res_byte_s), 32'd0);
      end
      @(negedge clk);
      chk("R6", "res_valid drops", 32'(res_valid), 32'd0);
    end

    // R2: erased sector
    for (int i = 0; i < 512; i++) sect[i] = 8'hFF;
    pulse_restart(4'b0010);
    stream(2'd1, 512);
    read_ctx(2'd1, raw, code);
    chk("R2", "erased raw", raw, 32'h0);
    chk("R2", "erased code", 32'(code), 32'h00FFFFFF);
    compare(24'hFFFFFF, code);
    chk("R2", "erased compare", 32'(res_status), 32'd0);

    // R1: patterned sector
    for (int i = 0; i < 512; i++) sect[i] = 8'((i * 37 + 11) % 256);
    pulse_restart(4'b0100);
    stream(2'd2, 512);
    read_ctx(2'd2, raw, code);
    exp_raw = model_raw(512);
    chk("R1", "pattern raw", raw, exp_raw);
    chk("R1", "pattern code", 32'(code), 32'(code_of(exp_raw)));
    code_a = code;

    // R8: end to end, one data bit flipped
    sect[200][6] = ~sect[200][6];
    pulse_restart(4'b0100);
    stream(2'd2, 512);
    read_ctx(2'd2, raw, code);
    compare(code_a, code);
    chk("R8", "flip status", 32'(res_status), 32'd1);
    chk("R8", "flip byte", 32'(res_byte), 32'd200);
    chk("R8", "flip bit", 32'(res_bit), 32'd6);

    // R3: read cleared the context
    read_ctx(2'd2, raw, code);
    chk("R3", "cleared raw", raw, 32'h0);
    // R4: stopped context ignores its bytes
    stream(2'd2, 16);
    read_ctx(2'd2, raw, code);
    chk("R4", "stopped raw", raw, 32'h0);

    // R4: bytes only reach the tagged chip select
    pulse_restart(4'b1001);
    stream(2'd3, 512);
    read_ctx(2'd0, raw, code);
    chk("R4", "other cs raw", raw, 32'h0);
    read_ctx(2'd3, raw, code);
    chk("R4", "tagged cs raw", raw, model_raw(512));

    // R5: a byte past the sector end changes nothing
    pulse_restart(4'b0010);
    stream(2'd1, 512);
    @(negedge clk); in_valid = 1'b1; in_cs = 2'd1; in_byte = 8'hA5; in_sof = 1'b0;
    @(negedge clk); in_valid = 1'b0;
    read_ctx(2'd1, raw, code);
    chk("R5", "past end raw", raw, model_raw(512));

    // R5: in_sof re-bases the offset mid-stream
    pulse_restart(4'b0010);
    stream(2'd1, 40);
    pulse_restart(4'b0010);
    stream(2'd1, 64);
    read_ctx(2'd1, raw, code);
    chk("R5", "sof rebase raw", raw, model_raw(64));

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule